// File: doc/BRIEF.md
# Shared-Counter Single-Slope Conversion Capture

This block holds the digital side of a converter in which every pixel digitises at once against one common ramp. A single counter sweeps through all 2^CODE_W steps. Its value goes out in Gray code to the ramp generator and to one small memory per pixel. While a pixel's comparator stays low, that pixel's memory copies the broadcast code every cycle. The first cycle the comparator reads high, the memory takes the code present in that cycle and keeps it until the next conversion.

A single-cycle start pulse begins a conversion. A busy flag covers the whole sweep, and a one-cycle done pulse marks its end. Stored values are read one pixel at a time through an index port. The read converts them from Gray to plain binary on the way out, so the per-pixel storage never needs a decoder. The number of pixels and the code width are parameters.

Top module: `ss_adc_capture`

## Requirements
- R1: After reset, busy and done are low, the broadcast ramp code is 0, and every pixel reads back 0.
- R2: A start pulse sets busy and the ramp code to 0 on the next clock edge, even when a conversion is already running (a restart).
- R3: While busy, the counter steps by one every cycle from 0 to 2^CODE_W-1, holding each step for exactly one cycle.
- R4: The ramp code broadcast on `ramp_code_o` is the Gray form of the step, step XOR (step >> 1), so consecutive steps differ in one bit.
- R5: A pixel stores the ramp code of the first cycle of the conversion in which its comparator input reads high. Readback returns that step as a binary number.
- R6: After a pixel has stored its code, any further change of its comparator within the same conversion has no effect on the stored value.
- R7: A pixel whose comparator never reads high during a conversion reads back the full-scale value 2^CODE_W-1.
- R8: Done goes high for exactly one cycle, on the edge after the final step's cycle. Busy falls on the same edge, and done is low throughout the sweep.
- R9: Between done and the next start, stored values and the ramp code do not change, whatever the comparator inputs do.
- R10: A start re-arms every pixel, so a pixel that stored a code in an earlier or aborted conversion captures afresh.
- R11: A read index at or beyond the pixel count returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins (or restarts) a conversion |
| cmp_i | input | NPIX | Comparator output of each pixel, high once the ramp has crossed the pixel level |
| rd_idx_i | input | IDX_W | Pixel selected for readback |
| rd_code_o | output | CODE_W | Stored code of the selected pixel, in binary |
| ramp_code_o | output | CODE_W | Gray-coded ramp step broadcast to the ramp generator |
| busy_o | output | 1 | High while the sweep runs |
| done_o | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The bench aims at the ends of the range. A comparator high from step 0 must store 0. A threshold of exactly full scale must look the same as one that never trips. An off-by-one in the capture stage would return step+1 or step-1 at these points, and a design that took the last code instead of the first would miss the early glitch. Pulsed comparators and late or early glitches show up a latch that keeps tracking after a trip (wrong value), or one that waits for a stable level. A restart halfway through a sweep, with every pixel already frozen, shows up pixels that are never re-armed: they would keep stale codes. Comparator activity while idle shows up a memory that keeps writing outside the sweep.

// File: rtl/ss_adc_pkg.sv
// Shared constants for the single-slope capture block.
// Assumes: consumers take these as parameter defaults only.
package ss_adc_pkg;
    localparam int CODE_W_DFLT = 8;
    localparam int NPIX_DFLT   = 6;
endpackage

// File: rtl/ss_ramp_counter.sv
// Global ramp sequencer: binary step counter, Gray broadcast, busy and done.
// Assumes: start_i is a single-cycle pulse; a start always wins over counting.
module ss_ramp_counter #(
    parameter int CODE_W = ss_adc_pkg::CODE_W_DFLT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [CODE_W-1:0] gray_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [CODE_W-1:0] LAST_STEP = '1;

    logic [CODE_W-1:0] step_q;
    logic              busy_q;
    logic              done_q;

    // Step sequencing: clear on start, advance while busy, flag the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                step_q <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (step_q == LAST_STEP) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    // Gray encoding of the current step for broadcast.
    always_comb gray_o = step_q ^ (step_q >> 1);

    assign busy_o = busy_q;
    assign done_o = done_q;

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_q && step_q == '0));
    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !start_i && step_q != LAST_STEP) |=> (step_q == $past(step_q) + 1'b1));
    assert_gray_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !start_i && step_q != LAST_STEP) |=> ($countones(gray_o ^ $past(gray_o)) == 1));
    assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/ss_pixel_latch.sv
// Per-pixel code memory: follows the broadcast code until its comparator trips.
// Assumes: track_i is high only during a sweep; arm_i coincides with start.
module ss_pixel_latch #(
    parameter int CODE_W = ss_adc_pkg::CODE_W_DFLT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              track_i,
    input  logic              cmp_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] mem_o
);
    logic [CODE_W-1:0] mem_q;
    logic              frozen_q;

    // Track the code until the first comparator high, then hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q    <= '0;
            frozen_q <= 1'b0;
        end else if (arm_i) begin
            frozen_q <= 1'b0;
        end else if (track_i && !frozen_q) begin
            mem_q <= code_i;
            if (cmp_i) frozen_q <= 1'b1;
        end
    end

    assign mem_o = mem_q;

    assert_capture_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (track_i && !frozen_q && cmp_i && !arm_i) |=> (mem_q == $past(code_i)));
    assert_hold_after_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_q && !arm_i) |=> $stable(mem_q));
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!track_i && !arm_i) |=> $stable(mem_q));
    assert_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> !frozen_q);
endmodule

// File: rtl/ss_code_reader.sv
// Readback mux with Gray-to-binary conversion.
// Assumes: indices at or beyond NPIX return zero.
module ss_code_reader #(
    parameter int NPIX   = ss_adc_pkg::NPIX_DFLT,
    parameter int CODE_W = ss_adc_pkg::CODE_W_DFLT,
    parameter int IDX_W  = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic [NPIX-1:0][CODE_W-1:0] mem_i,
    input  logic [IDX_W-1:0]            idx_i,
    output logic [CODE_W-1:0]           bin_o
);
    logic [CODE_W-1:0] gray_sel;

    // Select the addressed pixel, zero when out of range.
    always_comb begin
        gray_sel = '0;
        if (int'(idx_i) < NPIX) gray_sel = mem_i[idx_i];
    end

    // Prefix XOR from the top bit down turns Gray into binary.
    always_comb begin
        bin_o[CODE_W-1] = gray_sel[CODE_W-1];
        for (int i = CODE_W - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ gray_sel[i];
    end
endmodule

// File: rtl/ss_adc_capture.sv
// Top: one ramp sequencer shared by NPIX pixel latches plus a binary readback.
// Assumes: comparators are synchronous to clk and low before the ramp crosses.
module ss_adc_capture #(
    parameter int NPIX   = ss_adc_pkg::NPIX_DFLT,
    parameter int CODE_W = ss_adc_pkg::CODE_W_DFLT,
    parameter int IDX_W  = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NPIX-1:0]   cmp_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [CODE_W-1:0] rd_code_o,
    output logic [CODE_W-1:0] ramp_code_o,
    output logic              busy_o,
    output logic              done_o
);
    logic [CODE_W-1:0]             gray_bcast;
    logic                          busy;
    logic [NPIX-1:0][CODE_W-1:0]   pix_mem;

    ss_ramp_counter #(.CODE_W(CODE_W)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .gray_o  (gray_bcast),
        .busy_o  (busy),
        .done_o  (done_o)
    );

    // One latch per pixel, all fed from the same broadcast code.
    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        ss_pixel_latch #(.CODE_W(CODE_W)) u_pix (
            .clk     (clk),
            .rst_n   (rst_n),
            .arm_i   (start_i),
            .track_i (busy),
            .cmp_i   (cmp_i[p]),
            .code_i  (gray_bcast),
            .mem_o   (pix_mem[p])
        );
    end

    ss_code_reader #(.NPIX(NPIX), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_rd (
        .mem_i (pix_mem),
        .idx_i (rd_idx_i),
        .bin_o (rd_code_o)
    );

    assign ramp_code_o = gray_bcast;
    assign busy_o      = busy;
endmodule

// File: tb/ss_adc_capture_bench.sv
module ss_adc_capture_bench;
    localparam int NPIX   = 6;
    localparam int CODE_W = 8;
    localparam int IDX_W  = 3;
    localparam int FULL   = (1 << CODE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NPIX-1:0]   cmp;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [CODE_W-1:0] rd_code, ramp_code;
    logic              busy, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int thr  [NPIX];
    int thr2 [NPIX];
    bit pulse_mode = 0;
    bit force_all = 0;

    always #4 clk = ~clk;

    ss_adc_capture #(.NPIX(NPIX), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_ss_adc_capture (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp), .rd_idx_i(rd_idx),
        .rd_code_o(rd_code), .ramp_code_o(ramp_code), .busy_o(busy), .done_o(done)
    );

    function automatic int g2b(input logic [CODE_W-1:0] g);
        int b = 0;
        for (int i = CODE_W - 1; i >= 0; i--) b = b | ((((b >> (i + 1)) & 1) ^ int'(g[i])) << i);
        return b;
    endfunction

    // Comparator model: ramp level against each pixel's threshold.
    always_comb begin
        for (int p = 0; p < NPIX; p++) begin
            int s;
            s = g2b(ramp_code);
            cmp[p] = force_all
                   | (busy && (pulse_mode ? (s == thr[p]) : (s >= thr[p])))
                   | (busy && s == thr2[p]);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_code(input int p);
        int e = FULL;
        if (thr[p] <= FULL && thr[p] < e) e = thr[p];
        if (thr2[p] >= 0 && thr2[p] < e) e = thr2[p];
        return e;
    endfunction

    task automatic read_all(input string req);
        for (int p = 0; p < NPIX; p++) begin
            @(negedge clk);
            rd_idx = IDX_W'(p);
            #1;
            check(int'(rd_code) == expect_code(p), req, int'(rd_code), expect_code(p));
        end
    endtask

    // Full sweep: start, step and Gray checks, done timing.
    task automatic do_conv();
        int bad_step = 0, bad_done = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        check(busy == 1 && ramp_code == 0, "R2", int'(ramp_code), 0);
        for (int k = 0; k <= FULL; k++) begin
            if (k > 0) @(negedge clk);
            if (int'(ramp_code) != (k ^ (k >> 1)) || !busy) bad_step++;
            if (done) bad_done++;
        end
        check(bad_step == 0, "R3", bad_step, 0);
        check(bad_step == 0, "R4", bad_step, 0);
        @(negedge clk);
        check(done == 1 && busy == 0 && bad_done == 0, "R8", int'(done), 1);
        @(negedge clk);
        check(done == 0, "R8", int'(done), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy == 0 && done == 0 && ramp_code == 0, "R1", int'(busy) + int'(done) + int'(ramp_code), 0);
        for (int p = 0; p < NPIX; p++) begin
            rd_idx = IDX_W'(p); #1;
            check(rd_code == 0, "R1", int'(rd_code), 0);
        end
    endtask

    task automatic t_basic();
        int v [NPIX] = '{0, 1, 100, 254, 255, 300};
        pulse_mode = 0;
        for (int p = 0; p < NPIX; p++) begin thr[p] = v[p]; thr2[p] = -1; end
        do_conv();
        read_all("R5");
        rd_idx = 5; #1;
        check(int'(rd_code) == FULL, "R7", int'(rd_code), FULL);
    endtask

    task automatic t_glitch();
        int v [NPIX] = '{10, 50, 128, 180, 250, 400};
        int g [NPIX] = '{40, 90, 200, 20, -1, -1};
        pulse_mode = 1;
        for (int p = 0; p < NPIX; p++) begin thr[p] = v[p]; thr2[p] = g[p]; end
        do_conv();
        read_all("R6");
        pulse_mode = 0;
    endtask

    task automatic t_hold();
        logic [CODE_W-1:0] rc = ramp_code;
        force_all = 1;
        repeat (20) @(negedge clk);
        check(ramp_code == rc && busy == 0, "R9", int'(ramp_code), int'(rc));
        read_all("R9");
        force_all = 0;
    endtask

    task automatic t_restart();
        for (int p = 0; p < NPIX; p++) begin thr[p] = p; thr2[p] = -1; end
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (30) @(negedge clk);
        thr[0] = 77; thr[1] = 3; thr[2] = 255; thr[3] = 500; thr[4] = 140; thr[5] = 9;
        do_conv();
        read_all("R10");
    endtask

    task automatic t_oob();
        for (int i = NPIX; i < (1 << IDX_W); i++) begin
            @(negedge clk);
            rd_idx = IDX_W'(i); #1;
            check(rd_code == 0, "R11", int'(rd_code), 0);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NPIX; p++) begin thr[p] = 1000; thr2[p] = -1; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_glitch();
        t_hold();
        t_restart();
        t_oob();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule